// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits on the downstream side of a bridge between two buses. It holds the registers that describe three address windows: one for I/O space, one for ordinary memory and one for prefetchable memory. It compares each incoming request against the window chosen by the request's space type. The single output bit says whether the request falls inside that window and should be passed to the secondary bus.

Software programs the windows through a configuration port. The port takes a dword index, four byte enables and 32-bit write data, and it returns read data for the addressed dword without a clock delay. Each window is built from packed fields with a coarse granularity: 4 KB steps for I/O and 1 MB steps for both memory windows. The limit of each window is padded with ones below that granularity. Two optional widenings are fixed by parameters: 32-bit I/O addressing and 64-bit prefetchable addressing. When a widening is enabled, a capability nibble reports it and extra upper registers are used.

Top module: `bridge_window_decoder`

## Requirements
- R1: After reset no request is forwarded. Base fields read all ones (upper base registers included when their capability exists) and limit fields read zero.
- R2: I/O window. Bits 7:4 of dword 7 byte 0 give I/O base address bits 15:12, and base bits 11:0 are zero. Bits 15:12 of dword 7 give I/O limit address bits 15:12, and limit bits 11:0 are ones.
- R3: With 32-bit I/O capability, the low nibbles of dword 7 bytes 0 and 1 read 1. Dword 12 bits 15:0 give I/O base address bits 31:16, and bits 31:16 give I/O limit address bits 31:16. Without the capability the nibbles read 0, dword 12 reads zero, and writes to it are ignored.
- R4: Memory window. Dword 8 bits 15:4 give base address bits 31:20, and base bits 19:0 are zero. Dword 8 bits 31:20 give limit address bits 31:20, and limit bits 19:0 are ones. The low nibbles of dword 8 read 0.
- R5: Prefetchable window. Dword 9 is laid out like dword 8. With 64-bit capability its nibbles read 1, dword 10 gives base bits 63:32 and dword 11 gives limit bits 63:32. Without the capability the nibbles read 0, dwords 10 and 11 read zero, and writes to them are ignored.
- R6: req_space encodings: 0 selects the memory window, 1 the prefetchable window and 2 the I/O window. Code 3 is never forwarded.
- R7: A request is forwarded when base ≤ address ≤ limit, with both bounds inclusive. A window whose base exceeds its limit forwards nothing.
- R8: A configuration write changes only the byte lanes whose enable is set.
- R9: A write that changes a window is visible at req_fwd from the first clock edge after the write cycle. Without a write, the windows hold.
- R10: Dword 3 bits 23:16 read 0x01 with bit 7 equal to MULTI_FN. Dword 1 bits 31:16 and dword 7 bits 31:16 read 0x00A0, which reports 66 MHz and fast back-to-back capability.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Dword index into the configuration header |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| req_space | input | 2 | Request space type (R6 encoding) |
| req_addr | input | 64 | Request address |
| req_fwd | output | 1 | Request lies inside the selected window |

## Verification
A wrong field or window register appears in two places. It shows on cfg_rdata as soon as that dword is addressed. It also shows on req_fwd for the first request whose address lies at the edge of the window: one below the base, at the base, at the limit or one above the limit. Stimulus therefore programs a window and, in the next cycle, probes it at those four edge points as well as at a point inside it. Read-back of the written dword follows each write. A second instance with both widenings disabled shows whether writes to the upper registers leak through.

// File: rtl/bwd_pkg.sv
// Shared types and helpers for the bridge address window decoder.
// Assumes a 64-bit request address; window index equals the space code.
package bwd_pkg;
    localparam int ADDR_W   = 64;
    localparam int NUM_WIN  = 3;
    localparam int IO_GRAN  = 12;
    localparam int MEM_GRAN = 20;

    localparam logic [1:0] SPACE_MEM  = 2'd0;
    localparam logic [1:0] SPACE_PREF = 2'd1;
    localparam logic [1:0] SPACE_IO   = 2'd2;
    localparam logic [1:0] SPACE_RSVD = 2'd3;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
    } window_t;

    typedef window_t [NUM_WIN-1:0] win_set_t;

    typedef struct packed {
        logic [3:0]  io_base_hi;
        logic [3:0]  io_lim_hi;
        logic [15:0] io_base_up;
        logic [15:0] io_lim_up;
        logic [11:0] mem_base;
        logic [11:0] mem_lim;
        logic [11:0] pf_base;
        logic [11:0] pf_lim;
        logic [31:0] pf_base_up;
        logic [31:0] pf_lim_up;
    } fields_t;

    // Reset contents: bases at maximum, limits at zero, absent uppers at zero.
    function automatic fields_t reset_fields(bit io32, bit pf64);
        fields_t f;
        f.io_base_hi = 4'hF;
        f.io_lim_hi  = 4'h0;
        f.io_base_up = io32 ? 16'hFFFF : 16'h0000;
        f.io_lim_up  = 16'h0000;
        f.mem_base   = 12'hFFF;
        f.mem_lim    = 12'h000;
        f.pf_base    = 12'hFFF;
        f.pf_lim     = 12'h000;
        f.pf_base_up = pf64 ? 32'hFFFF_FFFF : 32'h0;
        f.pf_lim_up  = 32'h0;
        return f;
    endfunction

    // Expand packed fields into full-width base/limit pairs.
    function automatic win_set_t derive_windows(fields_t f);
        win_set_t w;
        w[SPACE_IO].base    = {32'h0, f.io_base_up, f.io_base_hi, {IO_GRAN{1'b0}}};
        w[SPACE_IO].limit   = {32'h0, f.io_lim_up, f.io_lim_hi, {IO_GRAN{1'b1}}};
        w[SPACE_MEM].base   = {32'h0, f.mem_base, {MEM_GRAN{1'b0}}};
        w[SPACE_MEM].limit  = {32'h0, f.mem_lim, {MEM_GRAN{1'b1}}};
        w[SPACE_PREF].base  = {f.pf_base_up, f.pf_base, {MEM_GRAN{1'b0}}};
        w[SPACE_PREF].limit = {f.pf_lim_up, f.pf_lim, {MEM_GRAN{1'b1}}};
        return w;
    endfunction
endpackage

// File: rtl/bwd_cfg_regs.sv
// Configuration register file for the window fields.
// Applies byte-enabled writes, keeps capability nibbles read-only and
// exposes the next-state fields plus a flag for writes into the window span.
// Assumes cfg_addr is a dword index into a 256-byte header.
module bwd_cfg_regs
    import bwd_pkg::*;
#(
    parameter bit IO32_CAP   = 1'b1,
    parameter bit PREF64_CAP = 1'b1,
    parameter bit MULTI_FN   = 1'b0,
    parameter int CFG_AW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] addr,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output fields_t           fields_d,
    output logic              span_wr
);
    localparam logic [CFG_AW-1:0] DW_STAT = CFG_AW'(1);
    localparam logic [CFG_AW-1:0] DW_HDR  = CFG_AW'(3);
    localparam logic [CFG_AW-1:0] DW_IO   = CFG_AW'(7);
    localparam logic [CFG_AW-1:0] DW_MEM  = CFG_AW'(8);
    localparam logic [CFG_AW-1:0] DW_PF   = CFG_AW'(9);
    localparam logic [CFG_AW-1:0] DW_PFBU = CFG_AW'(10);
    localparam logic [CFG_AW-1:0] DW_PFLU = CFG_AW'(11);
    localparam logic [CFG_AW-1:0] DW_IOUP = CFG_AW'(12);
    localparam logic [15:0] STATUS_VAL = 16'h00A0;
    localparam logic [7:0]  HDR_VAL    = {MULTI_FN, 7'h01};
    localparam logic [3:0]  IO_NIB     = {3'b000, IO32_CAP};
    localparam logic [3:0]  PF_NIB     = {3'b000, PREF64_CAP};

    fields_t f_q;

    // Next-state fields: merge enabled byte lanes into the addressed register.
    always_comb begin
        fields_d = f_q;
        if (wr_en) begin
            unique case (addr)
                DW_IO: begin
                    if (be[0]) fields_d.io_base_hi = wdata[7:4];
                    if (be[1]) fields_d.io_lim_hi  = wdata[15:12];
                end
                DW_MEM: begin
                    if (be[0]) fields_d.mem_base[3:0]  = wdata[7:4];
                    if (be[1]) fields_d.mem_base[11:4] = wdata[15:8];
                    if (be[2]) fields_d.mem_lim[3:0]   = wdata[23:20];
                    if (be[3]) fields_d.mem_lim[11:4]  = wdata[31:24];
                end
                DW_PF: begin
                    if (be[0]) fields_d.pf_base[3:0]  = wdata[7:4];
                    if (be[1]) fields_d.pf_base[11:4] = wdata[15:8];
                    if (be[2]) fields_d.pf_lim[3:0]   = wdata[23:20];
                    if (be[3]) fields_d.pf_lim[11:4]  = wdata[31:24];
                end
                DW_PFBU: begin
                    for (int i = 0; i < 4; i++)
                        if (be[i] && PREF64_CAP) fields_d.pf_base_up[8*i +: 8] = wdata[8*i +: 8];
                end
                DW_PFLU: begin
                    for (int i = 0; i < 4; i++)
                        if (be[i] && PREF64_CAP) fields_d.pf_lim_up[8*i +: 8] = wdata[8*i +: 8];
                end
                DW_IOUP: begin
                    for (int i = 0; i < 2; i++) begin
                        if (be[i] && IO32_CAP)   fields_d.io_base_up[8*i +: 8] = wdata[8*i +: 8];
                        if (be[i+2] && IO32_CAP) fields_d.io_lim_up[8*i +: 8]  = wdata[16+8*i +: 8];
                    end
                end
                default: ;
            endcase
        end
    end

    // Field storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= reset_fields(IO32_CAP, PREF64_CAP);
        else        f_q <= fields_d;
    end

    // Flag writes that touch the I/O base/limit bytes or the memory-to-upper span.
    always_comb begin
        span_wr = wr_en && (((addr == DW_IO) && (|be[1:0])) ||
                            ((addr >= DW_MEM) && (addr <= DW_IOUP) && (|be)));
    end

    // Read mux for the addressed dword.
    always_comb begin
        unique case (addr)
            DW_STAT: rdata = {STATUS_VAL, 16'h0000};
            DW_HDR:  rdata = {8'h00, HDR_VAL, 16'h0000};
            DW_IO:   rdata = {STATUS_VAL, f_q.io_lim_hi, IO_NIB, f_q.io_base_hi, IO_NIB};
            DW_MEM:  rdata = {f_q.mem_lim, 4'h0, f_q.mem_base, 4'h0};
            DW_PF:   rdata = {f_q.pf_lim, PF_NIB, f_q.pf_base, PF_NIB};
            DW_PFBU: rdata = f_q.pf_base_up;
            DW_PFLU: rdata = f_q.pf_lim_up;
            DW_IOUP: rdata = {f_q.io_lim_up, f_q.io_base_up};
            default: rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/bwd_window_regs.sv
// Holds the expanded windows, reloaded only when a write touches the span.
// Assumes fields_d is the register file's next state for this cycle.
module bwd_window_regs
    import bwd_pkg::*;
#(
    parameter bit IO32_CAP   = 1'b1,
    parameter bit PREF64_CAP = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  fields_t  fields_d,
    output win_set_t win
);
    // Recompute windows on a span write; start with every window disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)    win <= derive_windows(reset_fields(IO32_CAP, PREF64_CAP));
        else if (load) win <= derive_windows(fields_d);
    end
endmodule

// File: rtl/bwd_range_match.sv
// Inclusive range compare of one address against one window.
// Assumes an inverted window (base above limit) is disabled.
module bwd_range_match
    import bwd_pkg::*;
(
    input  window_t           win,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    // Hit when the window is valid and the address lies within it.
    always_comb begin
        hit = (win.base <= win.limit) && (addr >= win.base) && (addr <= win.limit);
    end
endmodule

// File: rtl/bridge_window_decoder.sv
// Top of the bridge address window decoder: register file, window
// registers, one comparator per window and a space-type select.
// Assumes req_space uses the bwd_pkg SPACE_* codes.
module bridge_window_decoder
    import bwd_pkg::*;
#(
    parameter bit IO32_CAP   = 1'b1,
    parameter bit PREF64_CAP = 1'b1,
    parameter bit MULTI_FN   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [5:0]        cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [1:0]        req_space,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_fwd
);
    localparam int NUM_CODE = 4;

    fields_t              fields_d;
    logic                 span_wr;
    win_set_t             win;
    logic [NUM_CODE-1:0]  hit;

    bwd_cfg_regs #(
        .IO32_CAP(IO32_CAP), .PREF64_CAP(PREF64_CAP), .MULTI_FN(MULTI_FN), .CFG_AW(6)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr), .be(cfg_be),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .fields_d(fields_d), .span_wr(span_wr)
    );

    bwd_window_regs #(
        .IO32_CAP(IO32_CAP), .PREF64_CAP(PREF64_CAP)
    ) u_win (
        .clk(clk), .rst_n(rst_n), .load(span_wr), .fields_d(fields_d), .win(win)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
        bwd_range_match u_match (.win(win[g]), .addr(req_addr), .hit(hit[g]));
    end
    for (genvar g = NUM_WIN; g < NUM_CODE; g++) begin : g_nohit
        assign hit[g] = 1'b0;
    end

    // Select the comparator named by the space code; unused codes never hit.
    always_comb begin
        req_fwd = hit[req_space];
    end
endmodule

// File: rtl/bwd_checker.sv
// Property checker for bridge_window_decoder, attached by bind.
// Assumes the window set is brought out by name from the top module.
module bwd_checker
    import bwd_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic [5:0]  cfg_addr,
    input logic [31:0] cfg_rdata,
    input logic [1:0]  req_space,
    input logic        req_fwd,
    input win_set_t    win
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !req_fwd);
    // R6
    rsvd_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_space == SPACE_RSVD) |-> !req_fwd);
    // R7
    io_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_space == SPACE_IO) && (win[SPACE_IO].base > win[SPACE_IO].limit)) |-> !req_fwd);
    // R7
    mem_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_space == SPACE_MEM) && (win[SPACE_MEM].base > win[SPACE_MEM].limit)) |-> !req_fwd);
    // R7
    pref_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_space == SPACE_PREF) && (win[SPACE_PREF].base > win[SPACE_PREF].limit)) |-> !req_fwd);
    // R9
    window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> $stable(win));
    // R3
    io_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 6'd7) |-> (cfg_rdata[3:0] == cfg_rdata[11:8]));
    // R5
    pf_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 6'd9) |-> (cfg_rdata[3:0] == cfg_rdata[19:16]));
    // R10
    status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 6'd1) |-> (cfg_rdata == 32'h00A0_0000));
endmodule

bind bridge_window_decoder bwd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_rdata(cfg_rdata), .req_space(req_space), .req_fwd(req_fwd), .win(win)
);

// File: tb/bridge_window_decoder_bench.sv
module bridge_window_decoder_bench;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wd = '0;
    logic [1:0]  sp = '0;
    logic [63:0] ra = '0;
    logic [31:0] rd0, rd1;
    logic        fw0, fw1;
    int checks = 0;
    int errors = 0;

    always #HALF clk = ~clk;

    bridge_window_decoder u_bridge_window_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr), .cfg_addr(addr), .cfg_be(be),
        .cfg_wdata(wd), .cfg_rdata(rd0), .req_space(sp), .req_addr(ra), .req_fwd(fw0));

    bridge_window_decoder #(.IO32_CAP(1'b0), .PREF64_CAP(1'b0), .MULTI_FN(1'b1))
    u_bridge_window_decoder_nocap (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr), .cfg_addr(addr), .cfg_be(be),
        .cfg_wdata(wd), .cfg_rdata(rd1), .req_space(sp), .req_addr(ra), .req_fwd(fw1));

    // Reference model: index 0 has both widenings, index 1 has none.
    logic [3:0]  m_iob[2], m_iol[2];
    logic [15:0] m_iobu[2], m_iolu[2];
    logic [11:0] m_mb[2], m_ml[2], m_pb[2], m_pl[2];
    logic [31:0] m_pbu[2], m_plu[2];

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_iob[k] = 4'hF; m_iol[k] = 4'h0;
            m_iobu[k] = (k == 0) ? 16'hFFFF : 16'h0; m_iolu[k] = 16'h0;
            m_mb[k] = 12'hFFF; m_ml[k] = 12'h0; m_pb[k] = 12'hFFF; m_pl[k] = 12'h0;
            m_pbu[k] = (k == 0) ? 32'hFFFF_FFFF : 32'h0; m_plu[k] = 32'h0;
        end
    endtask

    task automatic model_write(logic [5:0] idx, logic [3:0] b, logic [31:0] d);
        for (int k = 0; k < 2; k++) begin
            case (idx)
                6'd7: begin
                    if (b[0]) m_iob[k] = d[7:4];
                    if (b[1]) m_iol[k] = d[15:12];
                end
                6'd8: begin
                    if (b[0]) m_mb[k][3:0] = d[7:4];
                    if (b[1]) m_mb[k][11:4] = d[15:8];
                    if (b[2]) m_ml[k][3:0] = d[23:20];
                    if (b[3]) m_ml[k][11:4] = d[31:24];
                end
                6'd9: begin
                    if (b[0]) m_pb[k][3:0] = d[7:4];
                    if (b[1]) m_pb[k][11:4] = d[15:8];
                    if (b[2]) m_pl[k][3:0] = d[23:20];
                    if (b[3]) m_pl[k][11:4] = d[31:24];
                end
                6'd10: for (int i = 0; i < 4; i++) if (b[i] && k == 0) m_pbu[k][8*i +: 8] = d[8*i +: 8];
                6'd11: for (int i = 0; i < 4; i++) if (b[i] && k == 0) m_plu[k][8*i +: 8] = d[8*i +: 8];
                6'd12: for (int i = 0; i < 2; i++) begin
                    if (b[i] && k == 0)   m_iobu[k][8*i +: 8] = d[8*i +: 8];
                    if (b[i+2] && k == 0) m_iolu[k][8*i +: 8] = d[16+8*i +: 8];
                end
                default: ;
            endcase
        end
    endtask

    function automatic logic [127:0] exp_win(int k, logic [1:0] s);
        logic [63:0] b, l;
        case (s)
            2'd2: begin
                b = {32'h0, m_iobu[k], m_iob[k], 12'h000};
                l = {32'h0, m_iolu[k], m_iol[k], 12'hFFF};
            end
            2'd1: begin
                b = {m_pbu[k], m_pb[k], 20'h00000};
                l = {m_plu[k], m_pl[k], 20'hFFFFF};
            end
            default: begin
                b = {32'h0, m_mb[k], 20'h00000};
                l = {32'h0, m_ml[k], 20'hFFFFF};
            end
        endcase
        return {b, l};
    endfunction

    function automatic logic exp_fwd(int k, logic [1:0] s, logic [63:0] a);
        logic [127:0] w;
        if (s == 2'd3) return 1'b0;
        w = exp_win(k, s);
        return (w[127:64] <= w[63:0]) && (a >= w[127:64]) && (a <= w[63:0]);
    endfunction

    function automatic logic [31:0] exp_rd(int k, logic [5:0] idx);
        logic [3:0] nib;
        nib = (k == 0) ? 4'h1 : 4'h0;
        case (idx)
            6'd1:  return 32'h00A0_0000;
            6'd3:  return (k == 0) ? 32'h0001_0000 : 32'h0081_0000;
            6'd7:  return {16'h00A0, m_iol[k], nib, m_iob[k], nib};
            6'd8:  return {m_ml[k], 4'h0, m_mb[k], 4'h0};
            6'd9:  return {m_pl[k], nib, m_pb[k], nib};
            6'd10: return m_pbu[k];
            6'd11: return m_plu[k];
            6'd12: return {m_iolu[k], m_iobu[k]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(logic [5:0] idx, logic [3:0] b, logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = idx; be = b; wd = d;
        @(posedge clk);
        #1;
        wr = 1'b0;
        model_write(idx, b, d);
    endtask

    task automatic check_req(string tag, logic [1:0] s, logic [63:0] a);
        @(negedge clk);
        sp = s; ra = a;
        #1;
        chk({tag, " fwd"}, 64'(fw0), 64'(exp_fwd(0, s, a)));
        chk({tag, " fwd nocap"}, 64'(fw1), 64'(exp_fwd(1, s, a)));
    endtask

    task automatic check_rd(string tag, logic [5:0] idx);
        @(negedge clk);
        addr = idx;
        #1;
        chk({tag, " rd"}, 64'(rd0), 64'(exp_rd(0, idx)));
        chk({tag, " rd nocap"}, 64'(rd1), 64'(exp_rd(1, idx)));
    endtask

    // Probe the edges and interior of the window selected by s.
    task automatic probe_edges(string tag, logic [1:0] s);
        logic [127:0] w;
        logic [63:0] b, l;
        w = exp_win(0, s);
        b = w[127:64]; l = w[63:0];
        check_req(tag, s, b - 64'd1);
        check_req(tag, s, b);
        check_req(tag, s, l);
        check_req(tag, s, l + 64'd1);
        if (l >= b) check_req(tag, s, b + ({32'h0, $urandom} % (l - b + 64'd1)));
    endtask

    initial begin
        #(2 * HALF * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state and R10 fixed header fields, R3/R5 capability nibbles
        foreach (exp_rd_list[i]) check_rd("R1", exp_rd_list[i]);
        check_rd("R10", 6'd1);
        check_rd("R10", 6'd3);
        check_req("R1", 2'd0, 64'h0);
        check_req("R1", 2'd1, 64'hFFFF_FFFF_FFF0_0000);
        check_req("R1", 2'd2, 64'h0000_F000);

        // R9 update timing: old decode during the write cycle, new one after the edge
        @(negedge clk);
        wr = 1'b1; addr = 6'd8; be = 4'hF; wd = 32'h1FF0_1000; sp = 2'd0; ra = 64'h1000_0000;
        #1;
        chk("R9 before edge", 64'(fw0), 64'd0);
        @(posedge clk);
        #1;
        wr = 1'b0;
        model_write(6'd8, 4'hF, 32'h1FF0_1000);
        chk("R9 after edge", 64'(fw0), 64'd1);

        // R4 memory window edges
        probe_edges("R4", 2'd0);
        check_rd("R4", 6'd8);

        // R2/R3 I/O window with upper 16 bits
        do_write(6'd7, 4'b0011, 32'h0000_3121);
        do_write(6'd12, 4'hF, 32'h0001_0001);
        check_rd("R2", 6'd7);
        check_rd("R3", 6'd12);
        check_req("R2", 2'd2, 64'h0001_2000);
        check_req("R2", 2'd2, 64'h0001_1FFF);
        check_req("R2", 2'd2, 64'h0001_3FFF);
        check_req("R3", 2'd2, 64'h0001_4000);
        check_req("R3", 2'd2, 64'h0000_2000);

        // R5 prefetchable window above 4 GB
        do_write(6'd9, 4'hF, 32'h0FF0_0000);
        do_write(6'd10, 4'hF, 32'h0000_0001);
        do_write(6'd11, 4'hF, 32'h0000_0001);
        check_rd("R5", 6'd10);
        check_rd("R5", 6'd11);
        probe_edges("R5", 2'd1);
        check_req("R5", 2'd1, 64'h0000_0000_0000_0000);

        // R6 space select: memory address probed under every code
        check_req("R6", 2'd0, 64'h1080_0000);
        check_req("R6", 2'd1, 64'h1080_0000);
        check_req("R6", 2'd2, 64'h1080_0000);
        check_req("R6", 2'd3, 64'h1080_0000);
        check_req("R6", 2'd3, 64'h0001_2000);

        // R7 inverted window forwards nothing
        do_write(6'd8, 4'hF, 32'h1000_2000);
        check_req("R7", 2'd0, 64'h1000_0000);
        check_req("R7", 2'd0, 64'h2000_0000);

        // R8 partial byte enables
        do_write(6'd8, 4'b0010, 32'hAB00_CD00);
        check_rd("R8", 6'd8);
        do_write(6'd12, 4'b0100, 32'h5555_5555);
        check_rd("R8", 6'd12);

        // Random programming and probing
        for (int it = 0; it < 300; it++) begin
            int unsigned r;
            logic [11:0] bb, ll;
            r = $urandom % 4;
            bb = 12'($urandom % 64);
            ll = bb + 12'($urandom % 8) - 12'(($urandom % 5 == 0) ? 2 : 0);
            case (r)
                0: begin
                    logic [5:0] idx;
                    idx = 6'(1 + $urandom % 13);
                    do_write(idx, 4'($urandom), $urandom);
                    check_rd("R8", idx);
                end
                1: begin
                    do_write(6'd8, 4'hF, {ll, 4'h0, bb, 4'h0});
                    probe_edges("R7", 2'd0);
                end
                2: begin
                    do_write(6'd9, 4'hF, {ll, 4'h0, bb, 4'h0});
                    do_write(6'd10, 4'hF, $urandom % 3);
                    do_write(6'd11, 4'hF, $urandom % 3);
                    probe_edges("R5", 2'd1);
                end
                default: begin
                    do_write(6'd7, 4'b0011, {16'h0, ll[3:0], 4'h0, bb[3:0], 4'h0});
                    do_write(6'd12, 4'hF, {16'($urandom % 3), 16'($urandom % 3)});
                    probe_edges("R2", 2'd2);
                end
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    logic [5:0] exp_rd_list[6] = '{6'd7, 6'd8, 6'd9, 6'd10, 6'd11, 6'd12};
endmodule